// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits on the host side of a management bus and carries out one register read or register write per request. Some targets on the bus expose their internal register space through a pair of window registers rather than directly. The sequencer hides that difference from the requester. The requester supplies a direction, a device number, a register number and write data. The block later returns a one-cycle done pulse, a result code and the read data.

The target address and a capability flag are configuration inputs. A zero target address selects pass-through operation: each request becomes a single access to the requested device and register. A non-zero address on a capable target selects windowed operation. In that mode the block polls the busy flag of the window's command register and writes the data or command registers in the proper order. For reads it then fetches the result from the window's data register. The poll loop is bounded, and any failing bus access aborts the request at once. Downstream the block drives a single-access port with a valid/ready handshake. The serial engine behind that port is not part of this block.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: With `cfg_target_addr` equal to 0, a request makes exactly one downstream access. That access uses `bus_addr` = requested device, `bus_reg` = requested register and the requested direction. A read returns `bus_rdata` on `rsp_rdata` with code 0.
- R2: With a non-zero `cfg_target_addr` and `cfg_multi_ok` = 1, every access goes to `cfg_target_addr`. With a non-zero address and `cfg_multi_ok` = 0, the request ends with code 3 and makes no downstream access. Result codes are: 0 success, 1 bus error, 2 timeout, 3 rejected.
- R3: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_reg`, `bus_write` and `bus_wdata` hold their values.
- R4: A busy wait reads window register 0. It repeats the read while bit 15 of the returned data is 1 and moves on at the first read with bit 15 equal to 0.
- R5: A busy wait whose 16th read (`MAX_POLLS`) still shows bit 15 set ends the request with code 2, and no further access is made. Fifteen busy reads followed by a clear read succeed.
- R6: A windowed write runs in this order: busy wait, write of the request data to register 1, write of the command to register 0, busy wait.
- R7: A windowed read runs in this order: busy wait, write of the command to register 0, busy wait, read of register 1. The value read from register 1 is returned on `rsp_rdata`.
- R8: The command word has bit 15 = 1, bits 14:13 = 0 and bit 12 = 1. Bits 11:10 hold the operation, 2'b10 for a read and 2'b01 for a write. Bits 9:5 hold the device and bits 4:0 hold the register.
- R9: An access completed with `bus_err` = 1 ends the request in the following cycle with code 1, and no further access is made.
- R10: `req_ready` is 1 after reset and is 0 from the accepting cycle through the `rsp_done` cycle. `rsp_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_target_addr | input | 5 | Bus address of the target; 0 selects pass-through |
| cfg_multi_ok | input | 1 | Target supports the windowed scheme |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Internal device number |
| req_reg | input | 5 | Internal register number |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Request finished (one cycle) |
| rsp_code | output | 2 | Result code |
| rsp_rdata | output | 16 | Read result |
| bus_valid | output | 1 | Downstream access request |
| bus_ready | input | 1 | Downstream access completes this cycle |
| bus_write | output | 1 | Downstream direction |
| bus_addr | output | 5 | Downstream bus address |
| bus_reg | output | 5 | Downstream register number |
| bus_wdata | output | 16 | Downstream write data |
| bus_rdata | input | 16 | Downstream read data, valid with bus_ready |
| bus_err | input | 1 | Downstream access failed, valid with bus_ready |

## Verification
A corrupted sequencing state shows up directly in the downstream access log. It appears as a missing or extra poll, data written before the command out of turn, or a register-1 read on a write. It becomes visible at the first access after the fault, typically within two or three cycles. A wrong poll counter changes the number of reads before a timeout. It also turns a fifteen-busy-read case into a failure, so the exact poll counts at the limit are compared. A bad result register shows at the single `rsp_done` cycle as a wrong code or read value.

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq #(
  parameter int MAX_POLLS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  cfg_target_addr,
  input  logic        cfg_multi_ok,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_dev,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic [1:0]  rsp_code,
  output logic [15:0] rsp_rdata,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic        bus_write,
  output logic [4:0]  bus_addr,
  output logic [4:0]  bus_reg,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  input  logic        bus_err
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] C_OK = 2'd0, C_BUS = 2'd1, C_TMO = 2'd2, C_REJ = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_DIRECT, S_POLL1, S_WDATA, S_CMD, S_POLL2, S_RDATA, S_DONE
  } st_t;

  st_t         st;
  logic        is_wr;
  logic [4:0]  dev, regn, tgt;
  logic [15:0] wdata;
  logic [PW-1:0] polls;

  wire polling = (st == S_POLL1) || (st == S_POLL2);
  wire xfer    = bus_valid && bus_ready;
  wire busy    = bus_rdata[15];
  wire [15:0] cmd_word = {1'b1, 2'b00, 1'b1, is_wr ? 2'b01 : 2'b10, dev, regn};

  assign req_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_DONE);
  assign bus_valid = (st != S_IDLE) && (st != S_DONE);
  assign bus_addr  = (st == S_DIRECT) ? dev : tgt;
  assign bus_reg   = (st == S_DIRECT) ? regn :
                     (st == S_WDATA || st == S_RDATA) ? 5'd1 : 5'd0;
  assign bus_write = (st == S_DIRECT) ? is_wr : (st == S_WDATA || st == S_CMD);
  assign bus_wdata = (st == S_CMD) ? cmd_word :
                     (st == S_DIRECT || st == S_WDATA) ? wdata : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      is_wr     <= 1'b0;
      dev       <= '0;
      regn      <= '0;
      tgt       <= '0;
      wdata     <= '0;
      polls     <= '0;
      rsp_code  <= C_OK;
      rsp_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr     <= req_write;
          dev       <= req_dev;
          regn      <= req_reg;
          wdata     <= req_wdata;
          tgt       <= cfg_target_addr;
          polls     <= '0;
          rsp_code  <= C_OK;
          rsp_rdata <= '0;
          if (cfg_target_addr == 5'd0) st <= S_DIRECT;
          else if (cfg_multi_ok)       st <= S_POLL1;
          else begin
            rsp_code <= C_REJ;
            st       <= S_DONE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: if (xfer) begin
          if (bus_err) begin
            rsp_code <= C_BUS;
            st       <= S_DONE;
          end else begin
            case (st)
              S_DIRECT: begin
                if (!is_wr) rsp_rdata <= bus_rdata;
                st <= S_DONE;
              end
              S_WDATA: st <= S_CMD;
              S_CMD:   st <= S_POLL2;
              S_RDATA: begin
                rsp_rdata <= bus_rdata;
                st        <= S_DONE;
              end
              default: begin
                if (!busy) begin
                  polls <= '0;
                  if (st == S_POLL1) st <= is_wr ? S_WDATA : S_CMD;
                  else               st <= is_wr ? S_DONE : S_RDATA;
                end else if (polls == PW'(MAX_POLLS - 1)) begin
                  rsp_code <= C_TMO;
                  st       <= S_DONE;
                end else begin
                  polls <= polls + 1'b1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_reg)
      && $stable(bus_write) && $stable(bus_wdata));
  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cfg_target_addr != 5'd0 && !cfg_multi_ok
      |=> rsp_done && rsp_code == 2'd3 && !bus_valid);
  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    polling |-> polls < PW'(MAX_POLLS));
  // R8
  cmd_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_reg == 5'd0 && bus_addr == tgt && tgt != 5'd0
      && st != S_DIRECT |-> bus_wdata[15] && bus_wdata[12] && (bus_wdata[11] ^ bus_wdata[10]));
  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_err |=> rsp_done && rsp_code == 2'd1 && !bus_valid);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready ##1 !rsp_done && req_ready);
endmodule

// File: tb/tb_mgmt_indirect_seq.sv
module tb_mgmt_indirect_seq;
  logic clk = 0, rst_n = 0;
  logic [4:0] cfg_target_addr = 0;
  logic cfg_multi_ok = 0;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_dev = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rsp_done, bus_valid, bus_write;
  logic [1:0] rsp_code;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [4:0] bus_addr, bus_reg;
  logic bus_ready = 0, bus_err = 0;
  logic [15:0] bus_rdata = 0;

  mgmt_indirect_seq dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, busy_left = 0, post_busy = 0, err_idx = -1, nlog = 0;
  logic [15:0] data_reg = 0;
  logic        lw [0:63];
  logic [4:0]  la [0:63], lr [0:63];
  logic [15:0] ld [0:63];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bus_ready <= 0;
    bus_err   <= 0;
    if (bus_valid && !bus_ready) begin
      if (wcnt < lat) wcnt++;
      else begin
        automatic logic [15:0] rd = 16'h0;
        wcnt = 0;
        if (nlog < 64) begin
          lw[nlog] = bus_write; la[nlog] = bus_addr; lr[nlog] = bus_reg; ld[nlog] = bus_wdata;
        end
        if (cfg_target_addr == 0) rd = 16'hC000 | {6'd0, bus_addr, bus_reg};
        else if (bus_reg == 0 && !bus_write) begin
          rd = (busy_left > 0) ? 16'h8000 : 16'h0;
          if (busy_left > 0) busy_left--;
        end else if (bus_reg == 0) begin
          busy_left = post_busy;
          if (bus_wdata[11:10] == 2'b10) data_reg = 16'h5A00 ^ {6'd0, bus_wdata[9:0]};
        end else if (bus_write) data_reg = bus_wdata;
        else rd = data_reg;
        bus_err   <= (nlog == err_idx);
        bus_rdata <= rd;
        bus_ready <= 1;
        nlog++;
      end
    end
  end

  task automatic do_req(input bit wr, input logic [4:0] d, input logic [4:0] r, input logic [15:0] wd,
                        output logic [1:0] code, output logic [15:0] rd);
    int n;
    nlog = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_dev = d; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10 ready low after accept", req_ready, 0);
    n = 0;
    while (!rsp_done && n < 2000) begin
      @(negedge clk);
      n++;
      if (!rsp_done) chk(req_ready == 0, "R10 ready low while busy", req_ready, 0);
    end
    code = rsp_code;
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done && req_ready, "R10 done single pulse", {rsp_done, req_ready}, 1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1, "R10 reset ready", req_ready, 1);
    chk(bus_valid == 0 && rsp_done == 0, "R10 reset idle", {bus_valid, rsp_done}, 0);
  endtask

  task automatic t_direct;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 0; cfg_multi_ok = 1;
    do_req(0, 5'd9, 5'd4, 16'h0, c, d);
    chk(c == 0 && d == 16'hC124, "R1 direct read data", d, 16'hC124);
    chk(nlog == 1 && la[0] == 9 && lr[0] == 4 && !lw[0], "R1 direct read access", nlog, 1);
    do_req(1, 5'd17, 5'd30, 16'h1234, c, d);
    chk(c == 0 && nlog == 1 && lw[0] && la[0] == 17 && lr[0] == 30 && ld[0] == 16'h1234,
        "R1 direct write", ld[0], 16'h1234);
  endtask

  task automatic t_reject;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 4; cfg_multi_ok = 0;
    do_req(0, 5'd1, 5'd1, 16'h0, c, d);
    chk(c == 3 && nlog == 0, "R2 reject without access", {c, 8'(nlog)}, 12'h300);
  endtask

  task automatic t_iwrite;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 4; cfg_multi_ok = 1; busy_left = 0; post_busy = 2;
    do_req(1, 5'd3, 5'd7, 16'hBEEF, c, d);
    chk(c == 0 && nlog == 6, "R6 write access count", nlog, 6);
    chk(!lw[0] && lr[0] == 0, "R6 first poll", lr[0], 0);
    chk(lw[1] && lr[1] == 1 && ld[1] == 16'hBEEF, "R6 data before command", ld[1], 16'hBEEF);
    chk(lw[2] && lr[2] == 0 && ld[2] == 16'h9467, "R8 write command word", ld[2], 16'h9467);
    chk(!lw[5] && lr[5] == 0 && la[5] == 4 && la[1] == 4, "R2 target address used", la[5], 4);
  endtask

  task automatic t_iread;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 6; cfg_multi_ok = 1; busy_left = 1; post_busy = 0;
    do_req(0, 5'd2, 5'd1, 16'h0, c, d);
    chk(c == 0 && nlog == 5, "R4 poll repeats while busy", nlog, 5);
    chk(lw[2] && lr[2] == 0 && ld[2] == 16'h9841, "R8 read command word", ld[2], 16'h9841);
    chk(!lw[4] && lr[4] == 1, "R7 final data read", lr[4], 1);
    chk(d == 16'h5A41, "R7 read data returned", d, 16'h5A41);
  endtask

  task automatic t_timeout;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 4; cfg_multi_ok = 1; post_busy = 0;
    busy_left = 16;
    do_req(1, 5'd1, 5'd2, 16'h55, c, d);
    chk(c == 2 && nlog == 16, "R5 timeout after 16 busy reads", {c, 8'(nlog)}, 12'h210);
    busy_left = 15;
    do_req(1, 5'd1, 5'd2, 16'h55, c, d);
    chk(c == 0 && nlog == 19, "R5 15 busy reads then clear", {c, 8'(nlog)}, 12'h013);
    busy_left = 0; post_busy = 16;
    do_req(0, 5'd1, 5'd2, 16'h0, c, d);
    chk(c == 2 && nlog == 18, "R5 timeout in second wait", {c, 8'(nlog)}, 12'h212);
    busy_left = 0; post_busy = 0;
  endtask

  task automatic t_buserr;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 4; cfg_multi_ok = 1; err_idx = 1;
    do_req(1, 5'd5, 5'd5, 16'h77, c, d);
    chk(c == 1 && nlog == 2, "R9 abort on data write error", {c, 8'(nlog)}, 12'h102);
    cfg_target_addr = 0; err_idx = 0;
    do_req(0, 5'd5, 5'd5, 16'h0, c, d);
    chk(c == 1 && nlog == 1, "R9 direct error", {c, 8'(nlog)}, 12'h101);
    err_idx = -1;
  endtask

  task automatic t_stall;
    logic [1:0] c; logic [15:0] d;
    cfg_target_addr = 0; lat = 3;
    fork
      do_req(1, 5'd12, 5'd3, 16'hA5A5, c, d);
      begin
        logic [4:0] a0, r0; logic [15:0] w0; logic v0;
        @(negedge clk); @(negedge clk);
        a0 = bus_addr; r0 = bus_reg; w0 = bus_wdata; v0 = bus_valid;
        @(negedge clk); @(negedge clk);
        chk(v0 && bus_valid && bus_addr == a0 && bus_reg == r0 && bus_wdata == w0,
            "R3 held during stall", bus_wdata, w0);
      end
    join
    lat = 0;
    chk(c == 0 && nlog == 1, "R3 stalled access completes", nlog, 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_reject();
    t_iwrite();
    t_iread();
    t_timeout();
    t_buserr();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule